// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a full-duplex serial port driven from a small register interface. Address 0 holds a control and status byte. Address 1 is the data port. A write to address 1 loads the transmitter and starts a frame. A read from address 1 returns a separate receive buffer, so the byte last written for transmission cannot be read back.

The port has four modes. Mode 0 is a synchronous shift mode: data moves on a bidirectional data line, and the transmit pin carries the shift clock. Modes 1 to 3 are asynchronous and use a 16x oversampled receiver. Mode 1 carries a byte, while modes 2 and 3 carry a byte plus a ninth bit. The ninth bit supports address filtering on links shared by several processors. Modes 1 and 3 take their rate from an external oversampling tick. Mode 2 derives its rate from the system clock.

Two sticky flags, `ti_o` and `ri_o`, report a finished transmission and a stored reception. Software clears each flag by writing 0 to its bit.

Top module: `ser4_port`

## Requirements
- R1: The control byte reads back as written, with bits [7:6] = mode, [5] = filter enable, [4] = receive enable, [3] = transmit ninth bit, [2] = received ninth bit, [1] = TI and [0] = RI. A read of address 1 returns the receive buffer and never the byte written for transmission.
- R2: In mode 0, a data write shifts 8 bits LSB first on `rxd_o` with `rxd_oe_o` high. Each bit lasts 6 clocks. `txd_o` is low for the first 3 clocks of each bit and high for the last 3.
- R3: Mode 0 reception runs while RI is 0 and receive enable is 1. The port samples `rxd_i` in the last low clock of each shift clock, stores 8 bits LSB first and then sets RI.
- R4: Mode 1 frames have 10 bits: a start bit of 0, 8 data bits LSB first and a stop bit of 1. Each bit lasts 16 ticks. A stored frame puts its received stop bit into bit 2.
- R5: Modes 2 and 3 send and receive 11 bits. Bit 3 is sent as the ninth bit. The received ninth bit goes to bit 2. The received stop bit has no effect.
- R6: In mode 2 the oversampling tick comes from the clock: every 2 clocks when `rate_dbl_i` is 1, every 4 clocks otherwise. Modes 1 and 3 use `baud_tick_i`.
- R7: With receive enable at 0, an asynchronous frame leaves RI and the receive buffer untouched.
- R8: The receiver takes a majority vote of samples 7, 8 and 9 of each bit. A start bit that is not low at mid-bit is discarded.
- R9: In modes 2 and 3 with the filter enabled, a frame whose ninth bit is 0 neither sets RI nor loads the buffer.
- R10: In mode 1 with the filter enabled, a frame with a stop bit of 0 neither sets RI nor loads the buffer.
- R11: A frame that completes while RI is 1 is dropped, and the buffer and bit 2 keep their values.
- R12: TI rises when the stop bit starts in modes 1 to 3, and after the eighth bit in mode 0. TI and RI stay at 1 until software writes them to 0.
- R13: `txd_o` idles high, and `rxd_oe_o` is high only while a mode 0 transmission runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | 16x oversampling tick for modes 1 and 3 |
| rate_dbl_i | input | 1 | Mode 2 rate select: 1 = clock/32, 0 = clock/64 |
| rxd_i | input | 1 | Serial receive line |
| rxd_o | output | 1 | Mode 0 transmit data |
| rxd_oe_o | output | 1 | Output enable for rxd_o |
| txd_o | output | 1 | Async transmit line, or mode 0 shift clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control byte, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| ti_o | output | 1 | Transmit-done flag |
| ri_o | output | 1 | Receive-done flag |

## Verification
A wrong bit counter or oversampling counter in the transmitter shows up on `txd_o` in the same clock it goes wrong. A stretched or shortened bit moves every later edge, and the per-clock comparison of the line and of TI catches this within one bit time. Receiver faults take longer to reach the ports: a bad vote, a missed filter or a lost drop decision appears only when the frame ends, as a wrong RI, buffer or ninth bit. For that reason, each received frame is followed by a readback of both registers before the next frame starts.

// File: rtl/ser4_pkg.sv
package ser4_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_ASYNC8 = 2'd1,
    MODE_FIXED9 = 2'd2,
    MODE_VAR9   = 2'd3
  } ser_mode_e;

  typedef struct packed {
    ser_mode_e mode;
    logic      filt;
    logic      ren;
    logic      tb8;
    logic      rb8;
    logic      ti;
    logic      ri;
  } ser_ctrl_t;
endpackage

// File: rtl/ser4_shift0.sv
module ser4_shift0 #(
  parameter int DIV = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_start_i,
  input  logic       rx_start_i,
  input  logic [7:0] data_i,
  input  logic       rxd_i,
  output logic       sclk_o,
  output logic       dout_o,
  output logic       oe_o,
  output logic       tx_done_o,
  output logic       rx_done_o,
  output logic [7:0] rx_byte_o
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(DIV / 2);
  localparam logic [PW-1:0] PH_SAMP = PW'(DIV / 2 - 1);

  logic          act_q, dir_q;
  logic [PW-1:0] ph_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          last_w;

  assign last_w = act_q && ph_q == PH_LAST && bit_q == 3'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      dir_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else if (!act_q) begin
      ph_q  <= '0;
      bit_q <= '0;
      if (tx_start_i) begin
        act_q <= 1'b1;
        dir_q <= 1'b1;
        sh_q  <= data_i;
      end else if (rx_start_i) begin
        act_q <= 1'b1;
        dir_q <= 1'b0;
      end
    end else begin
      if (ph_q == PH_LAST) begin
        ph_q  <= '0;
        bit_q <= bit_q + 3'd1;
        if (dir_q) sh_q <= {1'b0, sh_q[7:1]};
        if (bit_q == 3'd7) act_q <= 1'b0;
      end else begin
        ph_q <= ph_q + PW'(1);
        if (!dir_q && ph_q == PH_SAMP) sh_q <= {rxd_i, sh_q[7:1]};
      end
    end
  end

  assign sclk_o    = act_q ? (ph_q >= PH_HALF) : 1'b1;
  assign dout_o    = sh_q[0];
  assign oe_o      = act_q & dir_q;
  assign tx_done_o = last_w & dir_q;
  assign rx_done_o = last_w & ~dir_q;
  assign rx_byte_o = sh_q;

  assert_phase_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (ph_q <= PH_LAST));
endmodule

// File: rtl/ser4_tx.sv
module ser4_tx #(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       nine_i,
  input  logic       b9_i,
  input  logic [7:0] data_i,
  output logic       txd_o,
  output logic       ti_set_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);

  logic          busy_q, txd_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    left_q;
  logic [9:0]    sh_q;
  logic          wrap_w;

  assign wrap_w = busy_q & tick_i & (cnt_q == CNT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      cnt_q  <= '0;
      left_q <= '0;
      sh_q   <= '1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
      cnt_q  <= '0;
      left_q <= nine_i ? 4'd10 : 4'd9;
      sh_q   <= {1'b1, nine_i ? b9_i : 1'b1, data_i};
    end else if (busy_q && tick_i) begin
      cnt_q <= wrap_w ? '0 : cnt_q + CW'(1);
      if (wrap_w) begin
        if (left_q == 4'd0) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[9:1]};
          left_q <= left_q - 4'd1;
        end
      end
    end
  end

  assign txd_o    = txd_q;
  assign ti_set_o = wrap_w & (left_q == 4'd1);

  assert_idle_high_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_q);
  assert_left_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q <= 4'd10));
endmodule

// File: rtl/ser4_rx.sv
module ser4_rx #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       ren_i,
  input  logic       nine_i,
  input  logic       rxd_i,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       b9_o,
  output logic       stop_ok_o
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] S_A   = CW'(MID - 2);
  localparam logic [CW-1:0] S_B   = CW'(MID - 1);
  localparam logic [CW-1:0] S_C   = CW'(MID);
  localparam logic [CW-1:0] S_END = CW'(OVS - 1);

  logic [SYNC-1:0] sync_q;
  logic            rx_s;

  generate
    if (SYNC == 1) begin : g_sync_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rxd_i;
      end
    end else begin : g_sync_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC-2:0], rxd_i};
      end
    end
  endgenerate

  assign rx_s = sync_q[SYNC-1];

  logic          run_q, v0_q, v1_q, maj_w;
  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q, last_w;
  logic [8:0]    sh_q;

  assign maj_w  = (v0_q & v1_q) | (v0_q & rx_s) | (v1_q & rx_s);
  assign last_w = nine_i ? 4'd10 : 4'd9;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      idx_q     <= '0;
      v0_q      <= 1'b1;
      v1_q      <= 1'b1;
      sh_q      <= '0;
      done_o    <= 1'b0;
      byte_o    <= '0;
      b9_o      <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (!run_q) begin
          if (en_i && ren_i && !rx_s) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            idx_q <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == S_END) ? '0 : cnt_q + CW'(1);
          if (cnt_q == S_END) idx_q <= idx_q + 4'd1;
          if (cnt_q == S_A) v0_q <= rx_s;
          if (cnt_q == S_B) v1_q <= rx_s;
          if (cnt_q == S_C) begin
            if (idx_q == 4'd0) begin
              if (maj_w) run_q <= 1'b0;  // false start
            end else if (idx_q == last_w) begin
              run_q     <= 1'b0;
              done_o    <= 1'b1;
              stop_ok_o <= maj_w;
              if (nine_i) begin
                byte_o <= sh_q[7:0];
                b9_o   <= sh_q[8];
              end else begin
                byte_o <= sh_q[8:1];
                b9_o   <= maj_w;
              end
            end else begin
              sh_q <= {maj_w, sh_q[8:1]};
            end
          end
        end
      end
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idx_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (idx_q <= 4'd10));
endmodule

// File: rtl/ser4_port.sv
module ser4_port
  import ser4_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int M0_DIV      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       rate_dbl_i,
  input  logic       rxd_i,
  output logic       rxd_o,
  output logic       rxd_oe_o,
  output logic       txd_o,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ti_o,
  output logic       ri_o
);
  ser_ctrl_t  ctrl_q;
  logic [7:0] rbuf_q;
  logic [1:0] div_q;

  logic wr_ctrl, wr_data, is_shift, nine, tick16;
  assign wr_ctrl  = wr_en_i & ~addr_i;
  assign wr_data  = wr_en_i & addr_i;
  assign is_shift = (ctrl_q.mode == MODE_SHIFT);
  assign nine     = ctrl_q.mode[1];
  assign tick16   = (ctrl_q.mode == MODE_FIXED9) ? (rate_dbl_i ? div_q[0] : &div_q)
                                                 : baud_tick_i;

  logic m0_sclk, m0_dout, m0_oe, m0_tx_done, m0_rx_done;
  logic [7:0] m0_byte;

  ser4_shift0 #(.DIV(M0_DIV)) u_shift0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_start_i (wr_data & is_shift),
    .rx_start_i (is_shift & ctrl_q.ren & ~ctrl_q.ri & ~wr_data),
    .data_i     (wdata_i),
    .rxd_i      (rxd_i),
    .sclk_o     (m0_sclk),
    .dout_o     (m0_dout),
    .oe_o       (m0_oe),
    .tx_done_o  (m0_tx_done),
    .rx_done_o  (m0_rx_done),
    .rx_byte_o  (m0_byte)
  );

  logic a_txd, a_ti_set;

  ser4_tx #(.OVS(OVS)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16),
    .start_i  (wr_data & ~is_shift),
    .nine_i   (nine),
    .b9_i     (ctrl_q.tb8),
    .data_i   (wdata_i),
    .txd_o    (a_txd),
    .ti_set_o (a_ti_set)
  );

  logic a_done, a_b9, a_stop_ok;
  logic [7:0] a_byte;

  ser4_rx #(.OVS(OVS), .SYNC(SYNC_STAGES)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16),
    .en_i      (~is_shift),
    .ren_i     (ctrl_q.ren),
    .nine_i    (nine),
    .rxd_i     (rxd_i),
    .done_o    (a_done),
    .byte_o    (a_byte),
    .b9_o      (a_b9),
    .stop_ok_o (a_stop_ok)
  );

  logic pass_async, take_async, take_m0, ti_set;
  assign pass_async = ~ctrl_q.filt | (nine ? a_b9 : a_stop_ok);
  assign take_async = a_done & ~is_shift & pass_async & ~ctrl_q.ri;
  assign take_m0    = m0_rx_done & is_shift & ~ctrl_q.ri;
  assign ti_set     = is_shift ? m0_tx_done : a_ti_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rbuf_q <= '0;
      div_q  <= '0;
    end else begin
      div_q <= div_q + 2'd1;
      if (wr_ctrl) ctrl_q <= ser_ctrl_t'(wdata_i);
      if (ti_set) ctrl_q.ti <= 1'b1;
      if (take_async) begin
        rbuf_q     <= a_byte;
        ctrl_q.rb8 <= a_b9;
        ctrl_q.ri  <= 1'b1;
      end else if (take_m0) begin
        rbuf_q    <= m0_byte;
        ctrl_q.ri <= 1'b1;
      end
    end
  end

  assign txd_o    = is_shift ? m0_sclk : a_txd;
  assign rxd_o    = m0_dout;
  assign rxd_oe_o = m0_oe;
  assign rdata_o  = addr_i ? rbuf_q : ctrl_q;
  assign ti_o     = ctrl_q.ti;
  assign ri_o     = ctrl_q.ri;

  assert_ti_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ti && !wr_ctrl) |=> ctrl_q.ti);
  assert_ri_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ri && !wr_ctrl) |=> ctrl_q.ri);
  assert_drop_keeps_buf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ri && !wr_ctrl) |=> ($stable(rbuf_q) && $stable(ctrl_q.rb8)));
endmodule

// File: tb/ser4_port_tb.sv
module ser4_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic baud_tick_i = 1'b0;
  logic rate_dbl_i = 1'b1;
  logic rxd_i = 1'b1;
  logic wr_en_i = 1'b0;
  logic addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic rxd_o, rxd_oe_o, txd_o, ti_o, ri_o;
  logic [7:0] rdata_o;

  ser4_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i), .rate_dbl_i(rate_dbl_i),
    .rxd_i(rxd_i), .rxd_o(rxd_o), .rxd_oe_o(rxd_oe_o), .txd_o(txd_o),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ti_o(ti_o), .ri_o(ri_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_cnt = 0;
  bit chk_txd = 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    baud_tick_i <= (tick_cnt % TICK_DIV) == 0;
    tick_cnt++;
  end

  // behavioural reference for the transmit side
  int         m_div;
  int         m_tick;
  bit         m_busy;
  logic       m_txd, m_ti, m_tb8;
  logic [1:0] m_mode;
  logic       bq[$];
  logic [1:0] m0q[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_tick = 0; m_busy = 0; m_txd = 1; m_ti = 0; m_tb8 = 0; m_mode = 0;
      bq.delete(); m0q.delete();
    end else begin
      logic tk;
      tk = (m_mode == 2) ? (rate_dbl_i ? m_div[0] : (m_div % 4 == 3)) : baud_tick_i;
      m_div = (m_div + 1) % 4;
      if (wr_en_i && !addr_i) m_ti = wdata_i[1];
      if (m0q.size() > 0) begin
        void'(m0q.pop_front());
        if (m0q.size() == 0) m_ti = 1;
      end else if (wr_en_i && addr_i && m_mode == 0) begin
        for (int j = 0; j < 48; j++) m0q.push_back({(j % 6) >= 3, wdata_i[j / 6]});
      end
      if (m_busy && tk) begin
        m_tick++;
        if (m_tick == 16) begin
          m_tick = 0;
          if (bq.size() == 0) begin
            m_busy = 0; m_txd = 1;
          end else begin
            m_txd = bq.pop_front();
            if (bq.size() == 0) m_ti = 1;
          end
        end
      end else if (!m_busy && wr_en_i && addr_i && m_mode != 0) begin
        bq.push_back(1'b0);
        for (int j = 0; j < 8; j++) bq.push_back(wdata_i[j]);
        if (m_mode[1]) bq.push_back(m_tb8);
        bq.push_back(1'b1);
        m_txd = bq.pop_front();
        m_busy = 1; m_tick = 0;
      end
      if (wr_en_i && !addr_i) begin
        m_mode = wdata_i[7:6];
        m_tb8  = wdata_i[3];
      end
    end
  end

  function automatic string line_tag(input logic [1:0] md);
    case (md)
      2'd0: return "R2";
      2'd1: return "R4";
      2'd2: return "R6";
      default: return "R5";
    endcase
  endfunction

  bit run_cmp = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni && run_cmp) begin
      if (chk_txd) chk(line_tag(m_mode), txd_o, (m0q.size() > 0) ? m0q[0][1] : m_txd);
      chk("R13", rxd_oe_o, m0q.size() > 0);
      if (m0q.size() > 0) chk("R2", rxd_o, m0q[0][0]);
      chk("R12", ti_o, m_ti);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic send(input logic [7:0] d, input bit nine, input logic b9,
                      input logic stop, input int cpb);
    logic [10:0] f;
    int n;
    f = nine ? {stop, b9, d, 1'b0} : {1'b0, stop, d, 1'b0};
    n = nine ? 11 : 10;
    for (int i = 0; i < n; i++) begin
      rxd_i = f[i];
      repeat (cpb) @(negedge clk_i);
    end
    rxd_i = 1'b1;
    repeat (2 * cpb) @(negedge clk_i);
  endtask

  task automatic chk_rx(input string req, input logic exp_ri, input logic [7:0] exp_buf);
    logic [7:0] v;
    chk(req, ri_o, exp_ri);
    rd(1'b1, v);
    chk(req, v, exp_buf);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    chk("R13", txd_o, 1'b1);
    chk("R13", rxd_oe_o, 1'b0);
    chk("R12", ti_o, 1'b0);
    chk("R12", ri_o, 1'b0);
    rd(1'b0, v); chk("R1", v, 8'h00);
    rd(1'b1, v); chk("R1", v, 8'h00);
    run_cmp = 1'b1;

    // mode 0 transmit
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hA5);
    repeat (60) @(negedge clk_i);
    chk("R12", ti_o, 1'b1);
    wr(1'b0, 8'h00);
    chk("R12", ti_o, 1'b0);

    // mode 1 transmit
    wr(1'b0, 8'h40);
    wr(1'b1, 8'h3C);
    repeat (700) @(negedge clk_i);
    chk("R12", ti_o, 1'b1);

    // mode 3 transmit, control readback, data port isolation
    wr(1'b0, 8'hF8);
    rd(1'b0, v); chk("R1", v, 8'hF8);
    wr(1'b1, 8'h96);
    rd(1'b1, v); chk("R1", v, 8'h00);
    repeat (760) @(negedge clk_i);
    wr(1'b0, 8'h08);

    // mode 2 transmit at both clock-derived rates
    rate_dbl_i = 1'b1;
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h0F);
    repeat (400) @(negedge clk_i);
    rate_dbl_i = 1'b0;
    wr(1'b0, 8'h88);
    wr(1'b1, 8'hF0);
    repeat (760) @(negedge clk_i);
    chk("R6", ti_o, 1'b1);
    rate_dbl_i = 1'b1;

    // mode 1 receive, stop bit lands in bit 2
    wr(1'b0, 8'h50);
    send(8'h6B, 0, 1'b0, 1'b1, 64);
    chk_rx("R4", 1'b1, 8'h6B);
    rd(1'b0, v); chk("R4", v[2], 1'b1);
    // RI still set: next frame dropped
    send(8'h11, 0, 1'b0, 1'b1, 64);
    chk_rx("R11", 1'b1, 8'h6B);

    // mode 1 filter: bad stop rejected, good stop accepted
    wr(1'b0, 8'h70);
    send(8'h22, 0, 1'b0, 1'b0, 64);
    repeat (200) @(negedge clk_i);
    chk_rx("R10", 1'b0, 8'h6B);
    send(8'h33, 0, 1'b0, 1'b1, 64);
    chk_rx("R10", 1'b1, 8'h33);

    // receive disabled
    wr(1'b0, 8'h40);
    send(8'h44, 0, 1'b0, 1'b1, 64);
    chk_rx("R7", 1'b0, 8'h33);

    // short low pulse is not a start bit
    wr(1'b0, 8'h50);
    rxd_i = 1'b0;
    repeat (12) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (800) @(negedge clk_i);
    chk_rx("R8", 1'b0, 8'h33);
    send(8'h55, 0, 1'b0, 1'b1, 64);
    chk_rx("R8", 1'b1, 8'h55);

    // mode 3 address filter
    wr(1'b0, 8'hF0);
    send(8'h77, 1, 1'b0, 1'b1, 64);
    chk_rx("R9", 1'b0, 8'h55);
    send(8'h88, 1, 1'b1, 1'b1, 64);
    chk_rx("R9", 1'b1, 8'h88);
    rd(1'b0, v); chk("R5", v[2], 1'b1);

    // mode 3 without filter: stop bit of 0 still accepted
    wr(1'b0, 8'hD0);
    send(8'h99, 1, 1'b0, 1'b0, 64);
    chk_rx("R5", 1'b1, 8'h99);
    rd(1'b0, v); chk("R5", v[2], 1'b0);

    // mode 2 receive at clock/32
    wr(1'b0, 8'h90);
    send(8'hC3, 1, 1'b1, 1'b1, 32);
    chk_rx("R6", 1'b1, 8'hC3);

    // mode 0 receive driven against the shift clock
    begin
      logic [7:0] pat;
      int k;
      logic prev;
      pat = 8'hB2; k = 0; prev = 1'b1;
      chk_txd = 1'b0;
      rxd_i = pat[0];
      wr(1'b0, 8'h10);
      for (int c = 0; c < 70; c++) begin
        @(negedge clk_i);
        if (!prev && txd_o) k++;
        if (k < 8) rxd_i = pat[k];
        prev = txd_o;
      end
      rxd_i = 1'b1;
      chk_rx("R3", 1'b1, 8'hB2);
      wr(1'b0, 8'h00);
      chk_txd = 1'b1;
      repeat (5) @(negedge clk_i);
      chk("R13", txd_o, 1'b1);
    end

    run_cmp = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule